// File: doc/BRIEF.md
# Multi-Channel Timer Unit with Shared Prescaler

This block is a group of general-purpose down-counting timers behind one 32-bit register port. A 16-bit prescaler divides the system clock and produces a one-cycle tick. All channels share that tick. Each channel has its own counter, reload value and control word. When a channel's counter is at zero and a tick arrives, the channel underflows. It then either reloads and keeps running, or stops. If its interrupt is enabled, it sets a sticky pending flag and pulses its own interrupt line.

Software reaches the unit through a plain request port: valid, write, address and write data. The unit window sits at offset 0x00. Channel n has a window of 0x10 bytes at offset 0x10*(n+1). Read data returns one cycle after the request. A read-only capability word reports how the unit was built.

Each channel is a two-state machine:
- CH_STOP: the counter holds.
- CH_COUNT: the counter steps down on each tick.

The transitions are:
- start: a control write with enable set moves CH_STOP to CH_COUNT.
- halt: a control write with enable clear moves CH_COUNT to CH_STOP.
- expire: an underflow with auto-restart clear moves CH_COUNT to CH_STOP.
- An underflow with auto-restart set keeps the channel in CH_COUNT.

Top module: `multi_timer_unit`

## Requirements
- R1: After reset, every scaler, reload, counter and control register reads 0. All interrupt lines are low. The capability word reads 0x342 with the default parameters.
- R2: A read request is answered on `rsp_rdata` with `rsp_valid` high exactly one cycle after the request cycle.
- R3: In the unit window, offset 0x0 is the scaler value and offset 0x4 is the scaler reload. Both keep only the low 16 bits of written data. The scaler steps down once per clock. At zero it reloads from the scaler reload and gives one tick, so ticks come every (scaler reload + 1) clocks.
- R4: Offset 0x8 of the unit window is the read-only capability word. Bits [2:0] hold the channel count modulo 8. Bits [7:3] hold the base interrupt number. Bit 8 reads 1 (one interrupt line per channel). Bit 9 reads 1 (no freeze support). Writes to it have no effect.
- R5: Channel n decodes at 0x10*(n+1). Offset +0x0 is the counter, +0x4 the reload and +0x8 the control word. The control bits are: bit 0 enable, bit 1 auto-restart, bit 2 load, bit 3 interrupt enable, bit 4 pending.
- R6: While a channel is in CH_COUNT, its counter drops by one on each tick. In CH_STOP it holds its value.
- R7: On underflow with auto-restart set, the counter takes the reload value. Without auto-restart, the counter stays at 0 and the enable bit clears.
- R8: On underflow with interrupt enable set, the pending bit sets and the channel's interrupt line is high for the following cycle. With interrupt enable clear, neither happens.
- R9: Writing a control word with bit 4 set clears the pending bit. Writing it with bit 4 clear leaves the pending bit unchanged.
- R10: A control write with the load bit set copies the reload into the counter. The load bit always reads 0.
- R11: Reads of unmapped offsets, misaligned offsets, or channels at or beyond the channel count return 0. Writes to them change nothing.
- R12: Only the low 8 address bits are decoded, so addresses wrap modulo 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address; low 8 bits decoded |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq | output | NUM_CH | One interrupt line per channel |

## Verification
- Register writes take effect at the clock edge that accepts them.
- A read captures the register at its own request edge and shows it at the next falling edge. The bench therefore issues requests back to back from one falling edge to the next and samples only there.
- An underflow reloads the counter and registers the interrupt at the same edge, so the interrupt line is visible one cycle after the underflow tick.
- Interrupt spacing is measured in whole cycles between rising interrupt samples and compared with (reload+1)*(scaler reload+1). This makes the check independent of the prescaler phase. Counter stepping is checked as the difference between two reads taken on consecutive edges.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // control word bit positions
    localparam int CTL_EN   = 0;
    localparam int CTL_RST  = 1;
    localparam int CTL_LOAD = 2;
    localparam int CTL_IE   = 3;
    localparam int CTL_PEND = 4;
    localparam int CTL_W    = 5;

    // register slot inside a 16-byte window
    typedef enum logic [1:0] {
        SEL_W0   = 2'd0,
        SEL_W4   = 2'd1,
        SEL_W8   = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_t;

    typedef enum logic {
        CH_STOP  = 1'b0,
        CH_COUNT = 1'b1
    } ch_state_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            val_wr,
    input  logic            rld_wr,
    input  logic [SC_W-1:0] wdata,
    output logic [SC_W-1:0] value_o,
    output logic [SC_W-1:0] reload_o,
    output logic            tick_o
);

    logic [SC_W-1:0] sc_q;
    logic [SC_W-1:0] reload_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_q     <= '0;
            reload_q <= '0;
        end else begin
            if (rld_wr)
                reload_q <= wdata;
            if (val_wr)
                sc_q <= wdata;
            else if (sc_q == '0)
                sc_q <= reload_q;
            else
                sc_q <= sc_q - 1'b1;
        end
    end

    always_comb begin
        tick_o   = (sc_q == '0);
        value_o  = sc_q;
        reload_o = reload_q;
    end

    // R3
    scaler_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !val_wr) |=> (sc_q == $past(reload_q)));

endmodule

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic [7:0]        addr,
    output logic              unit_hit,
    output logic [NUM_CH-1:0] ch_hit,
    output reg_sel_t          sel
);

    logic [3:0] win;
    assign win = addr[7:4];

    always_comb begin
        unique case (addr[3:0])
            4'h0:    sel = SEL_W0;
            4'h4:    sel = SEL_W4;
            4'h8:    sel = SEL_W8;
            default: sel = SEL_NONE;
        endcase
    end

    assign unit_hit = (sel != SEL_NONE) && (win == 4'd0);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_hit
        assign ch_hit[n] = (sel != SEL_NONE) && (win == 4'(n + 1));
    end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              cnt_wr,
    input  logic              rld_wr,
    input  logic              ctl_wr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CTL_W-1:0]  ctrl_o,
    output logic              irq_o
);

    ch_state_t        state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] reload_q;
    logic             restart_q;
    logic             ie_q;
    logic             pend_q;
    logic             irq_q;
    logic             underflow;

    // a register write in the same cycle takes priority over the tick
    assign underflow = (state_q == CH_COUNT) && tick_i && (count_q == '0)
                       && !cnt_wr && !ctl_wr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_STOP: begin
                if (ctl_wr && wdata[CTL_EN])
                    state_d = CH_COUNT;
            end
            CH_COUNT: begin
                if (ctl_wr && !wdata[CTL_EN])
                    state_d = CH_STOP;
                else if (underflow && !restart_q)
                    state_d = CH_STOP;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_STOP;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            reload_q  <= '0;
            restart_q <= 1'b0;
            ie_q      <= 1'b0;
            pend_q    <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (rld_wr)
                reload_q <= wdata;
            if (ctl_wr) begin
                restart_q <= wdata[CTL_RST];
                ie_q      <= wdata[CTL_IE];
            end
            if (cnt_wr)
                count_q <= wdata;
            else if (ctl_wr && wdata[CTL_LOAD])
                count_q <= reload_q;
            else if (underflow)
                count_q <= restart_q ? reload_q : count_q;
            else if (state_q == CH_COUNT && tick_i)
                count_q <= count_q - 1'b1;
            if (underflow && ie_q)
                pend_q <= 1'b1;
            else if (ctl_wr && wdata[CTL_PEND])
                pend_q <= 1'b0;
            irq_q <= underflow && ie_q;
        end
    end

    always_comb begin
        ctrl_o           = '0;
        ctrl_o[CTL_EN]   = (state_q == CH_COUNT);
        ctrl_o[CTL_RST]  = restart_q;
        ctrl_o[CTL_LOAD] = 1'b0;
        ctrl_o[CTL_IE]   = ie_q;
        ctrl_o[CTL_PEND] = pend_q;
        count_o          = count_q;
        reload_o         = reload_q;
        irq_o            = irq_q;
    end

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_STOP && !cnt_wr && !ctl_wr) |=> $stable(count_q));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_COUNT && tick_i && count_q != '0 && !cnt_wr && !ctl_wr)
        |=> (count_q == $past(count_q) - 1'b1));

    // R7
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !restart_q) |=> (state_q == CH_STOP && count_q == '0));

    // R8
    irq_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl_o[CTL_PEND]);

endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit
    import tmr_pkg::*;
#(
    parameter int NUM_CH   = 2,
    parameter int IRQ_BASE = 8,
    parameter int SC_W     = 16,
    parameter int CNT_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic [NUM_CH-1:0] irq
);

    localparam logic [31:0] CAP_WORD =
        {22'd0, 1'b1, 1'b1, 5'(IRQ_BASE), 3'(NUM_CH)};

    logic              unit_hit;
    logic [NUM_CH-1:0] ch_hit;
    reg_sel_t          sel;
    logic              wr_en;
    logic              rd_en;
    logic [31:0]       rd_mux;
    logic              unused_addr_bits;

    logic [SC_W-1:0]   sc_value;
    logic [SC_W-1:0]   sc_reload;
    logic              tick;

    logic [CNT_W-1:0]  ch_count  [NUM_CH];
    logic [CNT_W-1:0]  ch_reload [NUM_CH];
    logic [CTL_W-1:0]  ch_ctrl   [NUM_CH];

    assign wr_en = req_valid && req_write;
    assign rd_en = req_valid && !req_write;
    assign unused_addr_bits = ^req_addr[31:8];

    tmr_decode #(.NUM_CH(NUM_CH)) u_dec (
        .addr     (req_addr[7:0]),
        .unit_hit (unit_hit),
        .ch_hit   (ch_hit),
        .sel      (sel)
    );

    tmr_prescaler #(.SC_W(SC_W)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .val_wr   (wr_en && unit_hit && sel == SEL_W0),
        .rld_wr   (wr_en && unit_hit && sel == SEL_W4),
        .wdata    (req_wdata[SC_W-1:0]),
        .value_o  (sc_value),
        .reload_o (sc_reload),
        .tick_o   (tick)
    );

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_i   (tick),
            .cnt_wr   (wr_en && ch_hit[n] && sel == SEL_W0),
            .rld_wr   (wr_en && ch_hit[n] && sel == SEL_W4),
            .ctl_wr   (wr_en && ch_hit[n] && sel == SEL_W8),
            .wdata    (req_wdata[CNT_W-1:0]),
            .count_o  (ch_count[n]),
            .reload_o (ch_reload[n]),
            .ctrl_o   (ch_ctrl[n]),
            .irq_o    (irq[n])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (unit_hit) begin
            unique case (sel)
                SEL_W0:  rd_mux = 32'(sc_value);
                SEL_W4:  rd_mux = 32'(sc_reload);
                SEL_W8:  rd_mux = CAP_WORD;
                default: rd_mux = '0;
            endcase
        end
        for (int n = 0; n < NUM_CH; n++) begin
            if (ch_hit[n]) begin
                unique case (sel)
                    SEL_W0:  rd_mux = 32'(ch_count[n]);
                    SEL_W4:  rd_mux = 32'(ch_reload[n]);
                    SEL_W8:  rd_mux = 32'(ch_ctrl[n]);
                    default: rd_mux = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            if (rd_en)
                rsp_rdata <= rd_mux;
        end
    end

    // R2
    read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rsp_valid);

    // R2
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rsp_valid);

    // R11
    one_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({unit_hit, ch_hit}));

endmodule

// File: tb/tb_multi_timer_unit.sv
module tb_multi_timer_unit;

    localparam int NUM_CH = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [31:0]       req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NUM_CH-1:0] irq;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    multi_timer_unit #(.NUM_CH(NUM_CH)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // all bus tasks start and end on a falling edge
    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        d = rsp_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic wait_irq(input int idx, input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (irq[idx]) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset;
        chk("R1 irq low", {30'd0, irq}, 32'd0);
        chk("R1 rsp_valid low", {31'd0, rsp_valid}, 32'd0);
        rd_chk("R1 scaler", 32'h00, 32'd0);
        rd_chk("R1 scaler reload", 32'h04, 32'd0);
        rd_chk("R1 R4 capability", 32'h08, 32'h0000_0342);
        rd_chk("R1 ch0 counter", 32'h10, 32'd0);
        rd_chk("R1 ch0 reload", 32'h14, 32'd0);
        rd_chk("R1 ch1 control", 32'h28, 32'd0);
    endtask

    task automatic t_scaler_mask;
        wr(32'h04, 32'hFFFF_0005);
        rd_chk("R3 reload masked", 32'h04, 32'h0000_0005);
        wr(32'h00, 32'h7777_0010);
        rd_chk("R3 value masked", 32'h00, 32'h0000_0010);
        wr(32'h04, 32'd0);
        wr(32'h00, 32'd0);
    endtask

    task automatic t_capability_ro;
        wr(32'h08, 32'h0000_0000);
        rd_chk("R4 capability after write", 32'h08, 32'h0000_0342);
    endtask

    task automatic t_windows;
        wr(32'h24, 32'd9);
        rd_chk("R5 ch1 reload", 32'h24, 32'd9);
        rd_chk("R5 ch0 reload untouched", 32'h14, 32'd0);
        wr(32'h0000_0114, 32'd77);
        rd_chk("R12 wrapped write", 32'h14, 32'd77);
        rd_chk("R12 wrapped read", 32'hABCD_0108, 32'h0000_0342);
    endtask

    task automatic t_unmapped;
        wr(32'h12, 32'd7);
        rd_chk("R11 misaligned write ignored", 32'h14, 32'd77);
        wr(32'h34, 32'd5);
        rd_chk("R11 channel beyond count", 32'h34, 32'd0);
        rd_chk("R11 unit gap", 32'h0C, 32'd0);
        rd_chk("R11 misaligned read", 32'h11, 32'd0);
        rd_chk("R11 top window", 32'hF0, 32'd0);
    endtask

    task automatic t_load;
        wr(32'h14, 32'd50);
        wr(32'h18, 32'h04);
        rd_chk("R10 load copies reload", 32'h10, 32'd50);
        rd_chk("R10 load reads 0, stopped", 32'h18, 32'd0);
    endtask

    task automatic t_count_stop;
        logic [31:0] v1, v2;
        wr(32'h10, 32'd100);
        wr(32'h18, 32'h01);
        rd(32'h10, v1);
        rd(32'h10, v2);
        chk("R6 decrement per tick", v1 - v2, 32'd1);
        chk("R6 counter below start", {31'd0, (v1 <= 32'd100)}, 32'd1);
        wr(32'h18, 32'h00);
        rd(32'h10, v1);
        @(negedge clk);
        @(negedge clk);
        rd(32'h10, v2);
        chk("R6 stopped holds", v2, v1);
    endtask

    task automatic t_oneshot;
        bit seen;
        wr(32'h10, 32'd2);
        wr(32'h18, 32'h09);
        wait_irq(0, 50, seen);
        chk("R8 irq raised", {31'd0, seen}, 32'd1);
        @(negedge clk);
        chk("R8 irq one cycle", {31'd0, irq[0]}, 32'd0);
        rd_chk("R7 R8 oneshot control", 32'h18, 32'h18);
        rd_chk("R7 oneshot counter stays 0", 32'h10, 32'd0);
        wr(32'h18, 32'h08);
        rd_chk("R9 pending kept", 32'h18, 32'h18);
        wr(32'h18, 32'h18);
        rd_chk("R9 pending cleared", 32'h18, 32'h08);
    endtask

    task automatic t_no_ie;
        bit seen;
        wr(32'h14, 32'd1);
        wr(32'h10, 32'd1);
        wr(32'h18, 32'h03);
        wait_irq(0, 20, seen);
        chk("R8 no irq without enable", {31'd0, seen}, 32'd0);
        rd_chk("R8 no pending, restart runs", 32'h18, 32'h03);
        wr(32'h18, 32'h00);
    endtask

    task automatic t_period;
        bit seen;
        int k;
        wr(32'h04, 32'd2);
        wr(32'h24, 32'd3);
        wr(32'h20, 32'd3);
        wr(32'h28, 32'h0B);
        wait_irq(1, 100, seen);
        chk("R7 restart irq seen", {31'd0, seen}, 32'd1);
        k = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            k++;
            if (irq[1]) break;
        end
        chk("R3 R7 irq period", k, 32'd12);
        chk("R8 other channel quiet", {31'd0, irq[0]}, 32'd0);
        wr(32'h28, 32'h10);
        wr(32'h04, 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scaler_mask();
        t_capability_ro();
        t_windows();
        t_unmapped();
        t_load();
        t_count_stop();
        t_oneshot();
        t_no_ie();
        t_period();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule